// File: doc/BRIEF.md
# Multiplexed Address Visibility Bus Driver

This block turns a stream of internal bus accesses into the contents of a time-multiplexed external address bus. It generates an external bus clock that toggles on every edge of its own clock. Each access takes one high phase followed by one low phase. In the high phase the address lines carry the full access address. In the low phase the upper lines carry an access-type code and an instruction-queue status value. The lower sixteen lines carry internal read data, so an external observer can follow reads that never reach the data bus.

For internal reads the visibility data is arranged by lane. A misaligned word has its two bytes swapped. A single byte fills the unused lane with the matching address byte. The block also tells the pad logic what to do with the data bus in the low phase: the core drives it for a write, it is sampled for an external read, and it stays released for an internal read.

The access fields (address, size, direction, target, type code, queue status) are sampled on the edge that starts a high phase. The read data is sampled on the edge that starts the following low phase. Every output is a register.

Top module: `addrvis_bus`

## Requirements
- R1: Reset is synchronous and active high. In reset, `eclkOut`, `busAddr`, `dataDrive` and `dataSample` are all 0. After reset `eclkOut` toggles on every clock edge, and the first edge out of reset makes it 1.
- R2: On the edge that makes `eclkOut` 1, `busAddr` takes the value of `accAddr` sampled at that edge, and it holds that value for the high phase.
- R3: On the edge that makes `eclkOut` 0, `busAddr[22:20]` takes the `accType` of the current access.
- R4: In the low phase, `busAddr[19:16]` carries the `accQueue` value of the previous access. It is 0 for the first access after reset.
- R5: For an internal word read (`accSize`=1) at an even address, the low-phase `busAddr[15:0]` equals `rdData`, where `rdData[15:8]` is the byte at the access address.
- R6: For an internal word read at an odd address, the low-phase `busAddr[15:8]` is `rdData[7:0]` (the odd+1 byte) and `busAddr[7:0]` is `rdData[15:8]` (the odd byte).
- R7: For an internal byte read (`accSize`=0) at an even address, the byte is supplied in `rdData[7:0]`. The low-phase `busAddr[15:0]` is {`rdData[7:0]`, `accAddr[7:0]`}.
- R8: For an internal byte read at an odd address, the low-phase `busAddr[15:0]` is {`accAddr[15:8]`, `rdData[7:0]`}.
- R9: When the access is not an internal read, the low-phase `busAddr[15:0]` repeats `accAddr[15:0]`, and `rdData` has no effect on it.
- R10: In the high phase `dataDrive` and `dataSample` are both 0. In the low phase the outputs depend on the access: a write (`accRead`=0) gives `dataDrive`=1 and `dataSample`=0; an external read gives `dataDrive`=0 and `dataSample`=1; an internal read gives 0 on both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; each edge starts one external bus phase |
| rst | input | 1 | Synchronous active-high reset |
| accAddr | input | 23 | Access address |
| accSize | input | 1 | 1 = word, 0 = byte |
| accRead | input | 1 | 1 = read, 0 = write |
| accInternal | input | 1 | 1 = target is internal |
| accType | input | 3 | Access-type code shown in the low phase |
| accQueue | input | 4 | Instruction-queue status of this access |
| rdData | input | 16 | Internal read data, sampled at the start of the low phase |
| eclkOut | output | 1 | External bus clock |
| busAddr | output | 23 | Multiplexed address bus |
| dataDrive | output | 1 | Core drives the data bus |
| dataSample | output | 1 | Data bus carries external read data |

## Verification
A stuck or skipped phase flop shows at once as an `eclkOut` that stops alternating. It also puts an address on the bus where a type code belongs. A queue-status register that is wrongly updated only shows up one access later, because the low phase carries the previous access's value; the sweep checks this field in every low phase. A wrong lane choice or a missing byte swap corrupts `busAddr[15:0]` in the very low phase of the affected read. Each size, alignment, direction and target combination is therefore compared on the first low phase after it is issued.

// File: rtl/addrvis_pkg.sv
package addrvis_pkg;
  typedef enum logic {SZ_BYTE = 1'b0, SZ_WORD = 1'b1} accSize_e;

  typedef struct packed {
    logic loadAddr;  // next edge starts a high phase
    logic loadLow;   // next edge starts a low phase
  } strobe_t;
endpackage

// File: rtl/addrvis_ctrl.sv
module addrvis_ctrl
  import addrvis_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  output logic    eclkOut,
  output strobe_t strobe
);
  logic pastValid;

  always_ff @(posedge clk) begin
    if (rst) begin
      eclkOut   <= 1'b0;
      pastValid <= 1'b0;
    end else begin
      eclkOut   <= ~eclkOut;
      pastValid <= 1'b1;
    end
  end

  always_comb begin
    strobe.loadAddr = ~eclkOut;
    strobe.loadLow  = eclkOut;
  end

  // R1: the bus clock alternates on every edge out of reset
  p_phase_toggle_r1: assert property (@(posedge clk) disable iff (rst || !pastValid)
    eclkOut != $past(eclkOut));
endmodule

// File: rtl/addrvis_datapath.sv
module addrvis_datapath
  import addrvis_pkg::*;
#(
  parameter int ADDR_W = 23,
  parameter int DATA_W = 16,
  parameter int TYPE_W = 3,
  parameter int QST_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           strobe,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic              accSize,
  input  logic              accRead,
  input  logic              accInternal,
  input  logic [TYPE_W-1:0] accType,
  input  logic [QST_W-1:0]  accQueue,
  input  logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] busAddr,
  output logic              dataDrive,
  output logic              dataSample
);
  localparam int BYTE_W = DATA_W / 2;

  logic [ADDR_W-1:0] addrReg;
  logic              sizeReg, readReg, intReg;
  logic [TYPE_W-1:0] typeReg;
  logic [QST_W-1:0]  qCur, qPrev;
  logic [DATA_W-1:0] lowData;

  // lane arrangement of the low-phase visibility field
  always_comb begin
    lowData = addrReg[DATA_W-1:0];
    if (readReg && intReg) begin
      if (sizeReg == SZ_WORD) begin
        if (addrReg[0]) lowData = {rdData[BYTE_W-1:0], rdData[DATA_W-1:BYTE_W]};
        else            lowData = rdData;
      end else begin
        if (addrReg[0]) lowData = {addrReg[DATA_W-1:BYTE_W], rdData[BYTE_W-1:0]};
        else            lowData = {rdData[BYTE_W-1:0], addrReg[BYTE_W-1:0]};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addrReg    <= '0;
      sizeReg    <= 1'b0;
      readReg    <= 1'b0;
      intReg     <= 1'b0;
      typeReg    <= '0;
      qCur       <= '0;
      qPrev      <= '0;
      busAddr    <= '0;
      dataDrive  <= 1'b0;
      dataSample <= 1'b0;
    end else if (strobe.loadAddr) begin
      addrReg    <= accAddr;
      sizeReg    <= accSize;
      readReg    <= accRead;
      intReg     <= accInternal;
      typeReg    <= accType;
      qPrev      <= qCur;
      qCur       <= accQueue;
      busAddr    <= accAddr;
      dataDrive  <= 1'b0;
      dataSample <= 1'b0;
    end else if (strobe.loadLow) begin
      busAddr    <= {typeReg, qPrev, lowData};
      dataDrive  <= ~readReg;
      dataSample <= readReg & ~intReg;
    end
  end

  // R10: direction outputs are never both asserted
  p_dir_exclusive_r10: assert property (@(posedge clk) disable iff (rst)
    !(dataDrive && dataSample));
  // R10: data bus control released throughout the high phase
  p_high_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    strobe.loadLow |-> (!dataDrive && !dataSample));
  // R2: high phase shows the captured address
  p_high_addr_r2: assert property (@(posedge clk) disable iff (rst)
    strobe.loadLow |-> busAddr == addrReg);
  // R3: low phase shows the type code on the top lines
  p_type_low_r3: assert property (@(posedge clk) disable iff (rst)
    strobe.loadAddr |-> busAddr[ADDR_W-1 -: TYPE_W] == typeReg);
endmodule

// File: rtl/addrvis_bus.sv
module addrvis_bus
  import addrvis_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int TYPE_W = 3,
  parameter int QST_W  = 4,
  localparam int ADDR_W = DATA_W + QST_W + TYPE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic              accSize,
  input  logic              accRead,
  input  logic              accInternal,
  input  logic [TYPE_W-1:0] accType,
  input  logic [QST_W-1:0]  accQueue,
  input  logic [DATA_W-1:0] rdData,
  output logic              eclkOut,
  output logic [ADDR_W-1:0] busAddr,
  output logic              dataDrive,
  output logic              dataSample
);
  strobe_t strobe;

  addrvis_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .eclkOut (eclkOut),
    .strobe  (strobe)
  );

  addrvis_datapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .TYPE_W (TYPE_W),
    .QST_W  (QST_W)
  ) u_dp (
    .clk         (clk),
    .rst         (rst),
    .strobe      (strobe),
    .accAddr     (accAddr),
    .accSize     (accSize),
    .accRead     (accRead),
    .accInternal (accInternal),
    .accType     (accType),
    .accQueue    (accQueue),
    .rdData      (rdData),
    .busAddr     (busAddr),
    .dataDrive   (dataDrive),
    .dataSample  (dataSample)
  );
endmodule

// File: tb/addrvis_bus_test.sv
module addrvis_bus_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [22:0] accAddr = '0;
  logic        accSize = 1'b0, accRead = 1'b0, accInternal = 1'b0;
  logic [2:0]  accType = '0;
  logic [3:0]  accQueue = '0;
  logic [15:0] rdData = '0;
  logic        eclkOut, dataDrive, dataSample;
  logic [22:0] busAddr;
  int errors = 0, checks = 0;
  logic [3:0] prevQ = '0;

  always #2.5 clk = ~clk;

  addrvis_bus uut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doAccess(input logic [22:0] a, input logic sz, input logic rd,
                          input logic in, input logic [2:0] ty, input logic [3:0] q,
                          input logic [15:0] d);
    logic [15:0] expLow;
    accAddr = a; accSize = sz; accRead = rd; accInternal = in;
    accType = ty; accQueue = q; rdData = 16'hxxxx;
    @(posedge clk); @(negedge clk);
    check("R1 eclk high", 32'(eclkOut), 32'd1);
    check("R2 high addr", 32'(busAddr), 32'(a));
    check("R10 high dir", {30'd0, dataDrive, dataSample}, 32'd0);
    rdData = d;
    accAddr = ~a; accType = ~ty; accQueue = ~q; accSize = ~sz;
    @(posedge clk); @(negedge clk);
    if (rd && in) begin
      if (sz) expLow = a[0] ? {d[7:0], d[15:8]} : d;
      else    expLow = a[0] ? {a[15:8], d[7:0]} : {d[7:0], a[7:0]};
    end else expLow = a[15:0];
    check("R1 eclk low", 32'(eclkOut), 32'd0);
    check("R3 type", 32'(busAddr[22:20]), 32'(ty));
    check("R4 queue lag", 32'(busAddr[19:16]), 32'(prevQ));
    if (rd && in) check(sz ? (a[0] ? "R6 odd word" : "R5 even word")
                           : (a[0] ? "R8 odd byte" : "R7 even byte"),
                        32'(busAddr[15:0]), 32'(expLow));
    else check("R9 addr repeat", 32'(busAddr[15:0]), 32'(expLow));
    check("R10 low dir", {30'd0, dataDrive, dataSample},
          {30'd0, !rd, rd && !in});
    prevQ = q;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset eclk", 32'(eclkOut), 32'd0);
    check("R1 reset addr", 32'(busAddr), 32'd0);
    check("R1 reset dir", {30'd0, dataDrive, dataSample}, 32'd0);
    rst = 1'b0;
    for (int i = 0; i < 64; i++) begin
      logic [22:0] a;
      a = 23'(32'h2A5C3 * (i + 7)) ^ 23'(i[1:0]);
      a[1:0] = i[1:0];
      doAccess(a, i[2], i[3], i[4], 3'(i * 5), 4'(i * 3 + 1), 16'(16'hB1E7 * (i + 3)));
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule